// File: doc/BRIEF.md
# Scanning ADC Channel Control Registers

This block is the byte-wide register front of a data-acquisition channel. A host reaches it over a simple bus: a two-bit address, read and write strobes, and eight-bit write and read data. A range register holds the first and last channel of a scan. A current-channel counter drives the analogue multiplexer select and steps once for every completed conversion, wrapping back to the first channel after the last one. Writing the range register also produces a pulse that empties the sample FIFO.

The block also provides a four-bit general-purpose port. The four inputs are synchronised to the clock and can be read. The four outputs are latched on a write. Input 0 has two further jobs. Its rising edge sets a sticky trigger flag, which stays set until the host writes to the status address. While it is low, it holds off the first conversion of a new scan. The converter, the pacing timer and the FIFO storage lie outside the block. They appear only as strobes and levels.

Address map: 0 selects the scan range register, 1 selects the digital port, and 2 selects status. A read of address 3 returns zero.

Top module: `adc_chan_ctrl`

## Requirements
- R1: A write to address 0 takes the first channel from data bits 3:0 and the last channel from bits 7:4. On the next clock, chan_sel equals the first channel.
- R2: Each conv_done pulse advances chan_sel by one, counting modulo 16. When chan_sel equals the last channel, conv_done returns it to the first channel instead. A first channel above the last channel therefore scans through 15 and 0.
- R3: fifo_clr is high for exactly one cycle, on the clock after each write to address 0. It is never high after writes to other addresses.
- R4: A status read (address 2) returns these fields:
  - bits 3:0 hold the current channel;
  - bit 4 holds the trigger flag;
  - bit 5 holds cfg_single_ended (1 = sixteen single-ended, 0 = eight differential);
  - bit 6 holds cfg_unipolar (1 = unipolar);
  - bit 7 holds conv_busy (1 = busy).
- R5: A rising edge on din_pins[0] sets the trigger flag, after a two-flop synchroniser. A high pulse of two clock periods is enough. The flag stays set until any write to address 2 clears it.
- R6: While the trigger flag is set, further edges on din_pins[0] are not stored. A status write after such an edge leaves the flag at 0 until a new rising edge arrives.
- R7: A read of address 1 returns the synchronised din_pins in bits 3:0 and zero in bits 7:4.
- R8: A write to address 1 latches data bits 3:0 onto dout_pins and ignores bits 7:4. A read of address 1 still returns the inputs, not dout_pins.
- R9: conv_enable passes pacer_tick, except while the first conversion after a scan write is pending and synchronised din_pins[0] is low; then conv_enable is 0. Once one conversion has been enabled, din_pins[0] no longer gates conv_enable.
- R10: Reset sets these to zero: chan_sel, both range fields, dout_pins, the trigger flag and fifo_clr.
- R11: When a write to address 0 and conv_done fall in the same cycle, the write wins. chan_sel takes the new first channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, at least 10 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe; bus_rdata is zero when low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| din_pins | input | 4 | Asynchronous digital inputs; bit 0 is the trigger |
| dout_pins | output | 4 | Latched digital outputs |
| conv_done | input | 1 | One-cycle strobe from the converter at end of conversion |
| conv_busy | input | 1 | Converter busy level |
| cfg_single_ended | input | 1 | Input configuration level |
| cfg_unipolar | input | 1 | Amplifier range level |
| pacer_tick | input | 1 | Start request from the pacing timer |
| chan_sel | output | 4 | Current multiplexer channel |
| fifo_clr | output | 1 | One-cycle FIFO clear pulse |
| conv_enable | output | 1 | Gated start-of-conversion |

## Verification
A corrupted channel counter shows on chan_sel and in status bits 3:0 on the clock after the conv_done that caused it. Walking several ranges, one of them wrapping past 15, exposes an error in the increment or the wrap compare within one step. A trigger flag that sets or clears wrongly shows in status bit 4 about three clocks after the input edge, once the edge has crossed the synchroniser. A stuck hold-off state shows at conv_enable while pacer_tick is held high.

// File: rtl/adc_cc_pkg.sv
package adc_cc_pkg;
  localparam int CH_W  = 4;
  localparam int DIO_W = 4;
  localparam int BUS_W = 8;
  localparam int ADR_W = 2;

  localparam logic [ADR_W-1:0] ADDR_SCAN = 2'd0;
  localparam logic [ADR_W-1:0] ADDR_DIO  = 2'd1;
  localparam logic [ADR_W-1:0] ADDR_STAT = 2'd2;

  // Next channel in a scan: back to the first channel after the last,
  // otherwise a modulo 2**CH_W increment.
  function automatic logic [CH_W-1:0] next_chan(input logic [CH_W-1:0] cur,
                                                input logic [CH_W-1:0] first,
                                                input logic [CH_W-1:0] last);
    if (cur == last) return first;
    return cur + CH_W'(1);
  endfunction

  // Status byte assembly.
  function automatic logic [BUS_W-1:0] pack_status(input logic [CH_W-1:0] chan,
                                                   input logic flag,
                                                   input logic single_ended,
                                                   input logic unipolar,
                                                   input logic busy);
    return {busy, unipolar, single_ended, flag, chan};
  endfunction
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import adc_cc_pkg::*;
#(
  parameter int W = CH_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [2*W-1:0] range_in,
  input  logic           step,
  output logic [W-1:0]   chan,
  output logic [W-1:0]   first_chan,
  output logic [W-1:0]   last_chan,
  output logic           fifo_clr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_chan <= '0;
      last_chan  <= '0;
      chan       <= '0;
      fifo_clr   <= 1'b0;
    end else begin
      fifo_clr <= load;
      if (load) begin
        first_chan <= range_in[W-1:0];
        last_chan  <= range_in[2*W-1:W];
        chan       <= range_in[W-1:0];
      end else if (step) begin
        chan <= next_chan(chan, first_chan, last_chan);
      end
    end
  end
endmodule

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_async,
  output logic [W-1:0] pins_sync,
  output logic         rise0
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];
  logic         prev0;

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= pins_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev0 <= 1'b0;
    else        prev0 <= stg[LAST][0];
  end

  assign pins_sync = stg[LAST];
  assign rise0     = stg[LAST][0] & ~prev0;
endmodule

// File: rtl/conv_gate.sv
module conv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic trig_level,
  input  logic pacer_tick,
  output logic conv_enable
);
  logic first_pending;

  assign conv_enable = pacer_tick & ~(first_pending & ~trig_level);

  always_ff @(posedge clk) begin
    if (!rst_n)           first_pending <= 1'b1;
    else if (arm)         first_pending <= 1'b1;
    else if (conv_enable) first_pending <= 1'b0;
  end
endmodule

// File: rtl/dio_port.sv
module dio_port #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n)  dout <= '0;
    else if (we) dout <= wdata;
  end
endmodule

// File: rtl/adc_chan_ctrl.sv
module adc_chan_ctrl
  import adc_cc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADR_W-1:0] bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [DIO_W-1:0] din_pins,
  output logic [DIO_W-1:0] dout_pins,
  input  logic             conv_done,
  input  logic             conv_busy,
  input  logic             cfg_single_ended,
  input  logic             cfg_unipolar,
  input  logic             pacer_tick,
  output logic [CH_W-1:0]  chan_sel,
  output logic             fifo_clr,
  output logic             conv_enable
);
  // Named decode events, also observed by the checker.
  logic scan_we, dio_we, stat_we;
  assign scan_we = bus_wr && (bus_addr == ADDR_SCAN);
  assign dio_we  = bus_wr && (bus_addr == ADDR_DIO);
  assign stat_we = bus_wr && (bus_addr == ADDR_STAT);

  logic [CH_W-1:0]  start_chan, end_chan;
  logic [DIO_W-1:0] din_sync;
  logic             trig_rise;
  logic             trig_flag;

  scan_ctrl #(.W(CH_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (scan_we),
    .range_in  (bus_wdata[2*CH_W-1:0]),
    .step      (conv_done),
    .chan      (chan_sel),
    .first_chan(start_chan),
    .last_chan (end_chan),
    .fifo_clr  (fifo_clr)
  );

  trig_sync #(.W(DIO_W), .STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_async(din_pins),
    .pins_sync (din_sync),
    .rise0     (trig_rise)
  );

  conv_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (scan_we),
    .trig_level (din_sync[0]),
    .pacer_tick (pacer_tick),
    .conv_enable(conv_enable)
  );

  dio_port #(.W(DIO_W)) u_dio (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (dio_we),
    .wdata(bus_wdata[DIO_W-1:0]),
    .dout (dout_pins)
  );

  // Sticky trigger flag: the host's clear takes precedence over a new edge.
  always_ff @(posedge clk) begin
    if (!rst_n)         trig_flag <= 1'b0;
    else if (stat_we)   trig_flag <= 1'b0;
    else if (trig_rise) trig_flag <= 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        ADDR_DIO:  bus_rdata = BUS_W'(din_sync);
        ADDR_STAT: bus_rdata = pack_status(chan_sel, trig_flag, cfg_single_ended,
                                           cfg_unipolar, conv_busy);
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_chan_ctrl_chk.sv
module adc_chan_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       scan_we,
  input logic       stat_we,
  input logic       dio_we,
  input logic       conv_done,
  input logic [3:0] chan_sel,
  input logic [3:0] start_chan,
  input logic [3:0] end_chan,
  input logic       trig_flag,
  input logic       fifo_clr,
  input logic [3:0] dout_pins,
  input logic       conv_enable,
  input logic       pacer_tick
);
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    scan_we |=> chan_sel == $past(bus_wdata[3:0]));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !scan_we && chan_sel != end_chan) |=> chan_sel == 4'($past(chan_sel) + 4'd1));

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !scan_we && chan_sel == end_chan) |=> chan_sel == $past(start_chan));

  a_r3_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    scan_we |=> fifo_clr);

  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_we |=> !fifo_clr);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_flag && !stat_we) |=> trig_flag);

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> !trig_flag);

  a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !dio_we |=> $stable(dout_pins));

  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    conv_enable |-> pacer_tick);

  always @(negedge clk) begin
    if (rst_n && bus_rd && bus_addr == 2'd1)
      a_r7_upper: assert (bus_rdata[7:4] == 4'd0);
  end
endmodule

bind adc_chan_ctrl adc_chan_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .scan_we    (scan_we),
  .stat_we    (stat_we),
  .dio_we     (dio_we),
  .conv_done  (conv_done),
  .chan_sel   (chan_sel),
  .start_chan (start_chan),
  .end_chan   (end_chan),
  .trig_flag  (trig_flag),
  .fifo_clr   (fifo_clr),
  .dout_pins  (dout_pins),
  .conv_enable(conv_enable),
  .pacer_tick (pacer_tick)
);

// File: tb/adc_chan_ctrl_test.sv
module adc_chan_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] din_pins = '0;
  logic [3:0] dout_pins;
  logic       conv_done = 1'b0, conv_busy = 1'b0;
  logic       cfg_single_ended = 1'b0, cfg_unipolar = 1'b0, pacer_tick = 1'b0;
  logic [3:0] chan_sel;
  logic       fifo_clr, conv_enable;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_chan_ctrl uut (.*);

  // Vector: {op, addr, data, expected, mask}
  // op 0 = bus write, 1 = read and compare, 2 = conv_done then status channel, 3 = dout_pins
  localparam int N = 20;
  localparam logic [27:0] VECS [0:N-1] = '{
    {2'd0, 2'd0, 8'h31, 8'h00, 8'h00},  // range first 1, last 3
    {2'd1, 2'd2, 8'h00, 8'h01, 8'h0F},
    {2'd2, 2'd2, 8'h00, 8'h02, 8'h0F},
    {2'd2, 2'd2, 8'h00, 8'h03, 8'h0F},
    {2'd2, 2'd2, 8'h00, 8'h01, 8'h0F},  // wrap to first
    {2'd2, 2'd2, 8'h00, 8'h02, 8'h0F},
    {2'd0, 2'd0, 8'h2E, 8'h00, 8'h00},  // first 14, last 2: passes 15 -> 0
    {2'd1, 2'd2, 8'h00, 8'h0E, 8'h0F},
    {2'd2, 2'd2, 8'h00, 8'h0F, 8'h0F},
    {2'd2, 2'd2, 8'h00, 8'h00, 8'h0F},
    {2'd2, 2'd2, 8'h00, 8'h01, 8'h0F},
    {2'd2, 2'd2, 8'h00, 8'h02, 8'h0F},
    {2'd2, 2'd2, 8'h00, 8'h0E, 8'h0F},
    {2'd0, 2'd0, 8'h55, 8'h00, 8'h00},  // single channel
    {2'd2, 2'd2, 8'h00, 8'h05, 8'h0F},
    {2'd2, 2'd2, 8'h00, 8'h05, 8'h0F},
    {2'd0, 2'd1, 8'hF5, 8'h00, 8'h00},  // upper nibble ignored
    {2'd3, 2'd0, 8'h00, 8'h05, 8'h0F},
    {2'd0, 2'd1, 8'h0C, 8'h00, 8'h00},
    {2'd3, 2'd0, 8'h00, 8'h0C, 8'h0F}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic trig_pulse();
    @(negedge clk); din_pins[0] = 1'b1;
    repeat (2) @(negedge clk);
    din_pins[0] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 chan_sel", 8'(chan_sel), 8'h00);
    check("R10 dout_pins", 8'(dout_pins), 8'h00);
    check("R10 fifo_clr", 8'(fifo_clr), 8'h00);
    bus_read(2'd2, rd);
    check("R10 status", rd, 8'h00);

    for (int i = 0; i < N; i++) begin
      logic [1:0] op, a;
      logic [7:0] d, e, m;
      {op, a, d, e, m} = VECS[i];
      case (op)
        2'd0: bus_write(a, d);
        2'd1: begin bus_read(a, rd); check("R1 first channel", rd & m, e); end
        2'd2: begin pulse_done(); bus_read(2'd2, rd); check("R2 step", rd & m, e); end
        default: check("R8 dout latch", 8'(dout_pins) & m, e);
      endcase
    end

    // R8 / R7: read returns inputs, not outputs
    din_pins = 4'b1010;
    repeat (3) @(negedge clk);
    bus_read(2'd1, rd);
    check("R7 din read", rd, 8'h0A);
    check("R8 read not dout", rd, 8'h0A);
    din_pins = 4'b0000;
    repeat (4) @(negedge clk);
    bus_write(2'd2, 8'h00);

    // R3: pulse after scan write, one cycle only
    bus_write(2'd0, 8'h73);
    check("R3 fifo_clr high", 8'(fifo_clr), 8'h01);
    @(negedge clk);
    check("R3 fifo_clr one cycle", 8'(fifo_clr), 8'h00);
    bus_write(2'd1, 8'h03);
    check("R3 no pulse for dio", 8'(fifo_clr), 8'h00);

    // R11: write beats conv_done
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h96; bus_wr = 1'b1; conv_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; conv_done = 1'b0;
    check("R11 write wins", 8'(chan_sel), 8'h06);

    // R4: status upper bits
    conv_busy = 1'b1; cfg_unipolar = 1'b1; cfg_single_ended = 1'b0;
    bus_read(2'd2, rd);
    check("R4 status upper", rd & 8'hE0, 8'hC0);
    conv_busy = 1'b0; cfg_unipolar = 1'b0; cfg_single_ended = 1'b1;
    bus_read(2'd2, rd);
    check("R4 status lower", rd, 8'h26);

    // R5 / R6: trigger latch
    trig_pulse();
    bus_read(2'd2, rd);
    check("R5 flag set", rd & 8'h10, 8'h10);
    trig_pulse();
    bus_read(2'd2, rd);
    check("R5 flag held", rd & 8'h10, 8'h10);
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, rd);
    check("R6 no edge stored while set", rd & 8'h10, 8'h00);
    trig_pulse();
    bus_read(2'd2, rd);
    check("R5 new edge sets", rd & 8'h10, 8'h10);
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, rd);
    check("R5 cleared by write", rd & 8'h10, 8'h00);

    // R9: hold-off of the first conversion
    bus_write(2'd0, 8'h10);
    pacer_tick = 1'b1;
    #1 check("R9 held while low", 8'(conv_enable), 8'h00);
    @(negedge clk);
    din_pins[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 released", 8'(conv_enable), 8'h01);
    @(negedge clk);
    din_pins[0] = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 no gating after first", 8'(conv_enable), 8'h01);
    pacer_tick = 1'b0;
    #1 check("R9 follows pacer", 8'(conv_enable), 8'h00);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule